// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block carries out the register side effects of a small RISC core entering an exception handler. The core presents a one-cycle request with three values: a vector code, the address of the faulting instruction, and the effective data address involved. If exception recognition is enabled in the status register, the block commits the whole entry in one clock edge. It saves the instruction address and the effective address, sets supervisor mode, clears the external-interrupt enable, loads the vector code into both the next-fetch PC and the temporary PC, and pulses a redirect line for one cycle.

If a request arrives while recognition is disabled, the block does not vector. It moves to a halted state and stops. Software can rewrite the status register through a write port. An exception request in the same cycle beats that write.

The control is a two-state machine. **ST_RUN** is the normal state, where requests and writes are acted on. **ST_HALT** is a terminal state that only a reset leaves. There are three transitions: ST_RUN→ST_RUN on a taken exception, a software write or idle; ST_RUN→ST_HALT on a request while recognition is off; ST_HALT→ST_HALT on everything else. In each cycle the machine picks one action: none, take, abort or software write.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, `sr_o` equals the reset value 0x8041: supervisor bit 0 set, interrupt-enable bit 2 clear, recognition-enable bit 6 set, bit 15 set. `epc_o`, `eear_o`, `fetch_pc_o` and `temp_pc_o` are zero, and `redirect_o` and `halt_o` are low.
- R2: A request accepted in ST_RUN with `sr_o` bit 6 set loads `epc_o` with `exc_insn_addr` on the next edge.
- R3: On the same taken request, `eear_o` is loaded with `exc_eaddr`.
- R4: On a taken request, `sr_o` bit 0 becomes 1 and bit 2 becomes 0. Every other status bit keeps its previous value.
- R5: On a taken request, `fetch_pc_o` and `temp_pc_o` both become `exc_code`. `redirect_o` is high for exactly the cycle after each taken request and low in every other cycle.
- R6: A request in ST_RUN with `sr_o` bit 6 clear drives `halt_o` high from the next cycle. It leaves `sr_o`, `epc_o`, `eear_o`, `fetch_pc_o` and `temp_pc_o` unchanged and gives no redirect.
- R7: Once `halt_o` is high, it stays high until reset. All registered outputs hold, regardless of requests or writes.
- R8: In ST_RUN, `sw_we` without a request replaces `sr_o` with `sw_wdata` on the next edge. The save registers and PCs are left unchanged.
- R9: When `exc_valid` and `sw_we` are both high in ST_RUN, the write is discarded and the exception is handled as in R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_valid | input | 1 | One-cycle exception request strobe |
| exc_code | input | AW (32) | Exception code, used directly as the vector address |
| exc_insn_addr | input | AW (32) | Address of the faulting instruction |
| exc_eaddr | input | AW (32) | Effective address reported with the request |
| sw_we | input | 1 | Software status-register write strobe |
| sw_wdata | input | SR_W (16) | New status-register value |
| sr_o | output | SR_W (16) | Status register |
| epc_o | output | AW (32) | Saved exception PC |
| eear_o | output | AW (32) | Saved effective address |
| fetch_pc_o | output | AW (32) | Next fetch address |
| temp_pc_o | output | AW (32) | Temporary / delayed PC |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| halt_o | output | 1 | Fatal halt, held until reset |

## Verification
The bench starts with isolated requests at distinct codes and addresses, which show whether each value lands in its own save register. Back-to-back requests separate a true one-cycle redirect pulse from a held level. A software write that sets unrelated status bits, followed by a request, shows whether entry touches only the supervisor and interrupt bits. Coincident writes and requests expose the priority rule, and a request after clearing recognition shows the halt path and its freezing of all state. A long random stretch with periodic resets then mixes all of these.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } exc_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_TAKE  = 2'd1,
        ACT_ABORT = 2'd2,
        ACT_SWWR  = 2'd3
    } exc_act_e;

endpackage

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_entry_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     exc_valid,
    input  logic     exr_en,
    input  logic     sw_we,
    output exc_act_e act,
    output logic     halted
);

    exc_state_e state_q;
    exc_state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_nx;
    end

    always_comb begin
        act      = ACT_NONE;
        state_nx = state_q;
        halted   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (exc_valid) begin
                    if (exr_en) begin
                        act = ACT_TAKE;
                    end else begin
                        act      = ACT_ABORT;
                        state_nx = ST_HALT;
                    end
                end else if (sw_we) begin
                    act = ACT_SWWR;
                end
            end
            ST_HALT: begin
                halted = 1'b1;
            end
            default: begin
                state_nx = ST_RUN;
            end
        endcase
    end

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
    import exc_entry_pkg::*;
#(
    parameter int          SR_W     = 16,
    parameter int          SUPV_BIT = 0,
    parameter int          IE_BIT   = 2,
    parameter logic [15:0] SR_RESET = 16'h8041
) (
    input  logic            clk,
    input  logic            rst,
    input  exc_act_e        act,
    input  logic [SR_W-1:0] sw_wdata,
    output logic [SR_W-1:0] sr
);

    localparam logic [SR_W-1:0] SUPV_MASK = SR_W'(1) << SUPV_BIT;
    localparam logic [SR_W-1:0] IE_MASK   = SR_W'(1) << IE_BIT;
    localparam logic [SR_W-1:0] RST_VAL   = SR_W'(SR_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= RST_VAL;
        end else begin
            unique case (act)
                ACT_TAKE: sr <= (sr | SUPV_MASK) & ~IE_MASK;
                ACT_SWWR: sr <= sw_wdata;
                default:  sr <= sr;
            endcase
        end
    end

endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  exc_act_e      act,
    input  logic [AW-1:0] code,
    input  logic [AW-1:0] insn_addr,
    input  logic [AW-1:0] eaddr,
    output logic [AW-1:0] epc,
    output logic [AW-1:0] eear,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] temp_pc,
    output logic          redirect
);

    always_ff @(posedge clk) begin
        if (rst) begin
            epc      <= '0;
            eear     <= '0;
            fetch_pc <= '0;
            temp_pc  <= '0;
            redirect <= 1'b0;
        end else begin
            redirect <= (act == ACT_TAKE);
            if (act == ACT_TAKE) begin
                epc      <= insn_addr;
                eear     <= eaddr;
                fetch_pc <= code;
                temp_pc  <= code;
            end
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          SR_W     = 16,
    parameter int          SUPV_BIT = 0,
    parameter int          IE_BIT   = 2,
    parameter int          EXR_BIT  = 6,
    parameter logic [15:0] SR_RESET = 16'h8041
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_valid,
    input  logic [AW-1:0]   exc_code,
    input  logic [AW-1:0]   exc_insn_addr,
    input  logic [AW-1:0]   exc_eaddr,
    input  logic            sw_we,
    input  logic [SR_W-1:0] sw_wdata,
    output logic [SR_W-1:0] sr_o,
    output logic [AW-1:0]   epc_o,
    output logic [AW-1:0]   eear_o,
    output logic [AW-1:0]   fetch_pc_o,
    output logic [AW-1:0]   temp_pc_o,
    output logic            redirect_o,
    output logic            halt_o
);

    exc_act_e act;
    logic     exr_en;

    assign exr_en = sr_o[EXR_BIT];

    exc_entry_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .exc_valid (exc_valid),
        .exr_en    (exr_en),
        .sw_we     (sw_we),
        .act       (act),
        .halted    (halt_o)
    );

    exc_status_reg #(
        .SR_W     (SR_W),
        .SUPV_BIT (SUPV_BIT),
        .IE_BIT   (IE_BIT),
        .SR_RESET (SR_RESET)
    ) u_sr (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .sw_wdata (sw_wdata),
        .sr       (sr_o)
    );

    exc_save_bank #(
        .AW (AW)
    ) u_save (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .code      (exc_code),
        .insn_addr (exc_insn_addr),
        .eaddr     (exc_eaddr),
        .epc       (epc_o),
        .eear      (eear_o),
        .fetch_pc  (fetch_pc_o),
        .temp_pc   (temp_pc_o),
        .redirect  (redirect_o)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int AW       = 32,
    parameter int SR_W     = 16,
    parameter int SUPV_BIT = 0,
    parameter int IE_BIT   = 2,
    parameter int EXR_BIT  = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            exc_valid,
    input logic [AW-1:0]   exc_code,
    input logic [AW-1:0]   exc_insn_addr,
    input logic [AW-1:0]   exc_eaddr,
    input logic            sw_we,
    input logic [SR_W-1:0] sw_wdata,
    input logic [SR_W-1:0] sr_o,
    input logic [AW-1:0]   epc_o,
    input logic [AW-1:0]   eear_o,
    input logic [AW-1:0]   fetch_pc_o,
    input logic [AW-1:0]   temp_pc_o,
    input logic            redirect_o,
    input logic            halt_o
);

    logic take_c;
    logic abort_c;
    logic wr_c;
    assign take_c  = exc_valid && !halt_o && sr_o[EXR_BIT];
    assign abort_c = exc_valid && !halt_o && !sr_o[EXR_BIT];
    assign wr_c    = sw_we && !exc_valid && !halt_o;

    // R2
    epc_load_chk: assert property (@(posedge clk) disable iff (rst)
        take_c |=> epc_o == $past(exc_insn_addr));

    // R3
    eear_load_chk: assert property (@(posedge clk) disable iff (rst)
        take_c |=> eear_o == $past(exc_eaddr));

    // R4
    sr_entry_chk: assert property (@(posedge clk) disable iff (rst)
        take_c |=> sr_o[SUPV_BIT] && !sr_o[IE_BIT] && sr_o[EXR_BIT]);

    // R5
    vector_load_chk: assert property (@(posedge clk) disable iff (rst)
        take_c |=> redirect_o && fetch_pc_o == $past(exc_code) && temp_pc_o == $past(exc_code));

    // R5
    no_stray_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        !take_c |=> !redirect_o);

    // R6
    abort_halt_chk: assert property (@(posedge clk) disable iff (rst)
        abort_c |=> halt_o && $stable(sr_o) && $stable(epc_o) && $stable(fetch_pc_o));

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> halt_o && $stable(sr_o) && $stable(eear_o) && $stable(temp_pc_o));

    // R8
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_c |=> sr_o == $past(sw_wdata) && $stable(epc_o));

    // R9
    exc_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
        (take_c && sw_we) |=> sr_o[SUPV_BIT] && !sr_o[IE_BIT]);

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .AW       (AW),
    .SR_W     (SR_W),
    .SUPV_BIT (SUPV_BIT),
    .IE_BIT   (IE_BIT),
    .EXR_BIT  (EXR_BIT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .exc_valid     (exc_valid),
    .exc_code      (exc_code),
    .exc_insn_addr (exc_insn_addr),
    .exc_eaddr     (exc_eaddr),
    .sw_we         (sw_we),
    .sw_wdata      (sw_wdata),
    .sr_o          (sr_o),
    .epc_o         (epc_o),
    .eear_o        (eear_o),
    .fetch_pc_o    (fetch_pc_o),
    .temp_pc_o     (temp_pc_o),
    .redirect_o    (redirect_o),
    .halt_o        (halt_o)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int SR_W = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            exc_valid = 1'b0;
    logic [AW-1:0]   exc_code = '0;
    logic [AW-1:0]   exc_insn_addr = '0;
    logic [AW-1:0]   exc_eaddr = '0;
    logic            sw_we = 1'b0;
    logic [SR_W-1:0] sw_wdata = '0;
    logic [SR_W-1:0] sr_o;
    logic [AW-1:0]   epc_o, eear_o, fetch_pc_o, temp_pc_o;
    logic            redirect_o, halt_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 1'b0;
    string tag = "R1";

    // reference state
    logic [SR_W-1:0] m_sr;
    logic [AW-1:0]   m_epc, m_eear, m_pc, m_tpc;
    logic            m_redir, m_halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk           (clk),
        .rst           (rst),
        .exc_valid     (exc_valid),
        .exc_code      (exc_code),
        .exc_insn_addr (exc_insn_addr),
        .exc_eaddr     (exc_eaddr),
        .sw_we         (sw_we),
        .sw_wdata      (sw_wdata),
        .sr_o          (sr_o),
        .epc_o         (epc_o),
        .eear_o        (eear_o),
        .fetch_pc_o    (fetch_pc_o),
        .temp_pc_o     (temp_pc_o),
        .redirect_o    (redirect_o),
        .halt_o        (halt_o)
    );

    // behavioural reference: supervisor bit0, irq enable bit2, recognition bit6
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_sr <= 16'h8041; m_epc <= '0; m_eear <= '0;
            m_pc <= '0; m_tpc <= '0; m_redir <= 1'b0; m_halt <= 1'b0;
        end else if (m_halt) begin
            m_redir <= 1'b0;
        end else if (exc_valid) begin
            if (m_sr[6]) begin
                m_epc  <= exc_insn_addr;
                m_eear <= exc_eaddr;
                m_pc   <= exc_code;
                m_tpc  <= exc_code;
                m_sr   <= (m_sr | 16'h0001) & ~16'h0004;
                m_redir <= 1'b1;
            end else begin
                m_halt  <= 1'b1;
                m_redir <= 1'b0;
            end
        end else begin
            m_redir <= 1'b0;
            if (sw_we) m_sr <= sw_wdata;
        end
    end

    task automatic chk(input string what, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual=%h expected=%h at %0t", req, tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("sr",       "R4/R8", AW'(sr_o), AW'(m_sr));
            chk("epc",      "R2", epc_o, m_epc);
            chk("eear",     "R3", eear_o, m_eear);
            chk("fetch_pc", "R5", fetch_pc_o, m_pc);
            chk("temp_pc",  "R5", temp_pc_o, m_tpc);
            chk("redirect", "R5", AW'(redirect_o), AW'(m_redir));
            chk("halt",     "R6/R7", AW'(halt_o), AW'(m_halt));
        end
    end

    task automatic cyc(input logic v, input logic [AW-1:0] code, input logic [AW-1:0] ia,
                       input logic [AW-1:0] ea, input logic we, input logic [SR_W-1:0] wd);
        exc_valid = v; exc_code = code; exc_insn_addr = ia; exc_eaddr = ea;
        sw_we = we; sw_wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, '0, 1'b0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        tag = "R1"; do_reset();
        // R1 explicit reset state
        chk("reset sr", "R1", AW'(sr_o), 32'h8041);
        chk("reset halt", "R1", AW'(halt_o), 32'h0);
        chk("reset pc", "R1", fetch_pc_o, 32'h0);

        tag = "R2";
        cyc(1'b1, 32'h0000_0300, 32'h0000_1234, 32'hDEAD_0000, 1'b0, '0);
        idle(1);
        tag = "R3";
        cyc(1'b1, 32'h0000_0600, 32'h0000_2000, 32'h0BAD_F00D, 1'b0, '0);
        tag = "R5";   // back-to-back requests keep redirect high twice
        cyc(1'b1, 32'h0000_0800, 32'h0000_2004, 32'h1111_2222, 1'b0, '0);
        idle(2);

        tag = "R8";
        cyc(1'b0, '0, '0, '0, 1'b1, 16'hAB7D);
        idle(1);
        tag = "R4";   // unrelated bits must survive entry
        cyc(1'b1, 32'h0000_0500, 32'h0000_4444, 32'h5555_6666, 1'b0, '0);
        idle(1);
        tag = "R8";
        cyc(1'b0, '0, '0, '0, 1'b1, 16'h0044);
        idle(1);

        tag = "R9";
        cyc(1'b1, 32'h0000_0C00, 32'h0000_7000, 32'h0000_7777, 1'b1, 16'h0004);
        idle(1);

        tag = "R6";
        cyc(1'b0, '0, '0, '0, 1'b1, 16'h0005);
        cyc(1'b1, 32'h0000_0D00, 32'h0000_9000, 32'h0000_9999, 1'b0, '0);
        idle(1);
        tag = "R7";
        cyc(1'b1, 32'h0000_0E00, 32'h0000_A000, 32'h0000_AAAA, 1'b0, '0);
        cyc(1'b0, '0, '0, '0, 1'b1, 16'hFFFF);
        idle(2);

        tag = "R1"; do_reset();
        tag = "random";
        for (int k = 0; k < 400; k++) begin
            if (k % 50 == 49) begin
                do_reset();
            end else begin
                logic [SR_W-1:0] wd;
                wd = 16'($urandom);
                if (($urandom % 8) != 0) wd[6] = 1'b1;
                cyc(($urandom % 3) == 0, $urandom, $urandom, $urandom, ($urandom % 3) == 0, wd);
            end
        end
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule